// File: doc/BRIEF.md
# Low-Power Sleep Sequencer

This block decides when a small processor system goes to sleep, how deep it sleeps, and when and how it comes back. The processor signals a wait-for-interrupt event. On that cycle the sequencer takes the sleep level from a configuration register and moves to one of two sleep levels. In the light level (IDLE) the main clock keeps running. In the deep level (STANDBY) the main clock also stops. A configuration write reaches the register only after a fixed bridge delay. The register can be read back, so software can confirm the new level before it issues the wait.

While the system sleeps, the block drives clock-enable outputs for five domains: CPU, AHB, APB, main and generic clocks. It also drives run requests for the oscillators, a regulator mode and a RAM power mode. Peripherals may sleepwalk, which means they briefly use the bus clocks without waking the CPU. Each interrupt request carries a tag that says whether it is synchronous or asynchronous. Each peripheral also has a run-in-standby flag. From these the block decides which requests end each sleep level. On wake it restores the clocks in stages: the main clock first, then the buses, then the CPU.

Top module: `sleep_ctrl`

## Requirements
- R1: The sleep level register resets to IDLE (0); STANDBY is 1. A write presented with `cfg_wr_en` at one rising edge appears on `cfg_rd_lvl` after exactly BRIDGE_DLY+1 rising edges, counting that edge, and not earlier.
- R2: When `wfi_i` is high at a rising edge while the CPU runs and no qualifying wake request is pending, `mode_o` shows the register's level from the next cycle on. `mode_o` encodes ACTIVE=0, IDLE=1, STANDBY=2.
- R3: In IDLE with no sleepwalking, the CPU, AHB and APB enables are 0, `main_clk_en` is 1 and `gclk_en` equals `gclk_req`.
- R4: In STANDBY with no sleepwalking, the CPU, AHB, APB and main enables are 0 and `gclk_en` is all zeros.
- R5: While any `sw_active` bit is set in either sleep level, the AHB and APB enables are 1. In STANDBY, `gclk_en` also follows `gclk_req`. The CPU enable stays 0 and `mode_o` is unchanged.
- R6: Any set `irq_req` bit ends IDLE at the next rising edge.
- R7: STANDBY ends only on an `irq_req` bit whose `irq_async` bit is 1 (asynchronous) or whose `per_runstdby` bit is 1. Any other request leaves `mode_o` at STANDBY.
- R8: If a request that qualifies for the selected level is pending at the WFI edge, sleep is not entered and the CPU clock stays enabled.
- R9: After the edge that accepts a wake, `mode_o` is ACTIVE. The clocks then return in stages: for one cycle only `main_clk_en` is 1, in the next cycle AHB and APB are also enabled, and in the cycle after that the CPU clock is enabled.
- R10: An oscillator with its `osc_ondemand` bit at 1 runs only while `osc_req` is set, in every mode. With the bit at 0 it runs outside STANDBY, and in STANDBY it runs only if `osc_req` or `osc_runstdby` is set.
- R11: Outside STANDBY, `vreg_lowpwr` is 0 and `vreg_sel` is 0. In STANDBY, `vreg_lowpwr` is 1 and `vreg_sel` equals `stby_vreg_cfg`.
- R12: `ram_lowpwr` is 1 only in STANDBY and only when `stby_ram_lp` is 1.
- R13: During and after reset, `mode_o` is ACTIVE and the CPU, AHB, APB and main enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the sleep level register |
| cfg_wr_lvl | input | 1 | Level to write (0 IDLE, 1 STANDBY) |
| cfg_rd_lvl | output | 1 | Current register level |
| wfi_i | input | 1 | Wait-for-interrupt indication from the CPU |
| irq_req | input | NPERIPH | Enabled interrupt requests, one per peripheral |
| irq_async | input | NPERIPH | 1 marks the request as asynchronous |
| per_runstdby | input | NPERIPH | Peripheral run-in-standby flags |
| sw_active | input | NPERIPH | Peripheral sleepwalking in progress |
| gclk_req | input | NGCLK | Generic clock requests |
| osc_req | input | NOSC | Oscillator run requests from users |
| osc_ondemand | input | NOSC | On-demand setting per oscillator |
| osc_runstdby | input | NOSC | Run-in-standby setting per oscillator |
| stby_vreg_cfg | input | VREG_W | Regulator mode to use in STANDBY |
| stby_ram_lp | input | 1 | RAM low-power select for STANDBY |
| cpu_clk_en | output | 1 | CPU clock enable |
| ahb_clk_en | output | 1 | AHB clock enable |
| apb_clk_en | output | 1 | APB clock enable |
| main_clk_en | output | 1 | Main clock enable |
| gclk_en | output | NGCLK | Generic clock enables |
| osc_run | output | NOSC | Oscillator run outputs |
| vreg_lowpwr | output | 1 | Regulator in low-power mode |
| vreg_sel | output | VREG_W | Selected low-power regulator mode |
| ram_lowpwr | output | 1 | RAM in low-power state |
| mode_o | output | 2 | Current mode: 0 ACTIVE, 1 IDLE, 2 STANDBY |

## Verification
The bench builds the block with four peripherals, three generic clocks, two oscillators, a 2-bit regulator field and a bridge delay of two. The delay of two puts a whole cycle between the write edge and the first visible change, so reading the register too early can be detected. Four peripherals are enough to set requests that differ only in their asynchronous tag or their run-in-standby flag. That separates the STANDBY wake rule from the IDLE one. Two oscillators with different on-demand settings let both oscillator rules be observed in the same cycle.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

    typedef enum logic {
        LVL_IDLE    = 1'b0,
        LVL_STANDBY = 1'b1
    } sleep_lvl_e;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'd0,
        MODE_IDLE    = 2'd1,
        MODE_STANDBY = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_STBY    = 3'd2,
        ST_WK_MAIN = 3'd3,
        ST_WK_BUS  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sleep_cfg_bridge.sv
module sleep_cfg_bridge #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lvl,
    output logic cfg_lvl
);
    typedef struct packed {
        logic [DLY-1:0] vld;
        logic [DLY-1:0] val;
        logic           cfg;
    } bridge_t;

    bridge_t br_d, br_q;

    always_comb begin
        br_d = br_q;
        br_d.vld[0] = wr_en;
        br_d.val[0] = wr_lvl;
        for (int i = 1; i < DLY; i++) begin
            br_d.vld[i] = br_q.vld[i-1];
            br_d.val[i] = br_q.val[i-1];
        end
        if (br_q.vld[DLY-1]) begin
            br_d.cfg = br_q.val[DLY-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_q <= '0;
        end else begin
            br_q <= br_d;
        end
    end

    assign cfg_lvl = br_q.cfg;

endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual #(
    parameter int NPERIPH = 4
) (
    input  logic [NPERIPH-1:0] irq_req,
    input  logic [NPERIPH-1:0] irq_async,
    input  logic [NPERIPH-1:0] per_runstdby,
    input  logic [NPERIPH-1:0] sw_active,
    output logic               wake_idle,
    output logic               wake_stby,
    output logic               sw_any
);
    logic [NPERIPH-1:0] stby_ok;

    for (genvar p = 0; p < NPERIPH; p++) begin : g_qual
        assign stby_ok[p] = irq_req[p] & (irq_async[p] | per_runstdby[p]);
    end

    assign wake_idle = |irq_req;
    assign wake_stby = |stby_ok;
    assign sw_any    = |sw_active;

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_i,
    input  logic       cfg_lvl,
    input  logic       wake_idle,
    input  logic       wake_stby,
    output seq_state_e state
);
    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_RUN: begin
                if (wfi_i) begin
                    if (cfg_lvl == LVL_STANDBY) begin
                        if (!wake_stby) seq_d.st = ST_STBY;
                    end else begin
                        if (!wake_idle) seq_d.st = ST_IDLE;
                    end
                end
            end
            ST_IDLE:    if (wake_idle) seq_d.st = ST_WK_MAIN;
            ST_STBY:    if (wake_stby) seq_d.st = ST_WK_MAIN;
            ST_WK_MAIN: seq_d.st = ST_WK_BUS;
            ST_WK_BUS:  seq_d.st = ST_RUN;
            default:    seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= ST_RUN;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;

endmodule

// File: rtl/sleep_out_dec.sv
module sleep_out_dec
    import sleep_pkg::*;
#(
    parameter int NGCLK  = 3,
    parameter int NOSC   = 2,
    parameter int VREG_W = 2
) (
    input  seq_state_e        state,
    input  logic              sw_any,
    input  logic [NGCLK-1:0]  gclk_req,
    input  logic [NOSC-1:0]   osc_req,
    input  logic [NOSC-1:0]   osc_ondemand,
    input  logic [NOSC-1:0]   osc_runstdby,
    input  logic [VREG_W-1:0] stby_vreg_cfg,
    input  logic              stby_ram_lp,
    output logic              cpu_clk_en,
    output logic              ahb_clk_en,
    output logic              apb_clk_en,
    output logic              main_clk_en,
    output logic [NGCLK-1:0]  gclk_en,
    output logic [NOSC-1:0]   osc_run,
    output logic              vreg_lowpwr,
    output logic [VREG_W-1:0] vreg_sel,
    output logic              ram_lowpwr,
    output logic [1:0]        mode_o
);
    logic in_stby;
    logic in_sleep;

    assign in_stby  = (state == ST_STBY);
    assign in_sleep = (state == ST_IDLE) || in_stby;

    always_comb begin
        cpu_clk_en  = (state == ST_RUN);
        main_clk_en = !in_stby;
        if (in_sleep) begin
            ahb_clk_en = sw_any;
            apb_clk_en = sw_any;
        end else begin
            ahb_clk_en = (state != ST_WK_MAIN);
            apb_clk_en = (state != ST_WK_MAIN);
        end
        gclk_en = (in_stby && !sw_any) ? '0 : gclk_req;
        unique case (state)
            ST_IDLE: mode_o = MODE_IDLE;
            ST_STBY: mode_o = MODE_STANDBY;
            default: mode_o = MODE_ACTIVE;
        endcase
        vreg_lowpwr = in_stby;
        vreg_sel    = in_stby ? stby_vreg_cfg : '0;
        ram_lowpwr  = in_stby && stby_ram_lp;
    end

    for (genvar o = 0; o < NOSC; o++) begin : g_osc
        always_comb begin
            if (osc_ondemand[o]) begin
                osc_run[o] = osc_req[o];
            end else if (in_stby) begin
                osc_run[o] = osc_req[o] | osc_runstdby[o];
            end else begin
                osc_run[o] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int NPERIPH    = 4,
    parameter int NGCLK      = 3,
    parameter int NOSC       = 2,
    parameter int VREG_W     = 2,
    parameter int BRIDGE_DLY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_lvl,
    output logic               cfg_rd_lvl,
    input  logic               wfi_i,
    input  logic [NPERIPH-1:0] irq_req,
    input  logic [NPERIPH-1:0] irq_async,
    input  logic [NPERIPH-1:0] per_runstdby,
    input  logic [NPERIPH-1:0] sw_active,
    input  logic [NGCLK-1:0]   gclk_req,
    input  logic [NOSC-1:0]    osc_req,
    input  logic [NOSC-1:0]    osc_ondemand,
    input  logic [NOSC-1:0]    osc_runstdby,
    input  logic [VREG_W-1:0]  stby_vreg_cfg,
    input  logic               stby_ram_lp,
    output logic               cpu_clk_en,
    output logic               ahb_clk_en,
    output logic               apb_clk_en,
    output logic               main_clk_en,
    output logic [NGCLK-1:0]   gclk_en,
    output logic [NOSC-1:0]    osc_run,
    output logic               vreg_lowpwr,
    output logic [VREG_W-1:0]  vreg_sel,
    output logic               ram_lowpwr,
    output logic [1:0]         mode_o
);
    logic       cfg_lvl;
    logic       wake_idle;
    logic       wake_stby;
    logic       sw_any;
    seq_state_e state;

    sleep_cfg_bridge #(.DLY(BRIDGE_DLY)) u_bridge (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_lvl  (cfg_wr_lvl),
        .cfg_lvl (cfg_lvl)
    );

    sleep_wake_qual #(.NPERIPH(NPERIPH)) u_qual (
        .irq_req      (irq_req),
        .irq_async    (irq_async),
        .per_runstdby (per_runstdby),
        .sw_active    (sw_active),
        .wake_idle    (wake_idle),
        .wake_stby    (wake_stby),
        .sw_any       (sw_any)
    );

    sleep_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_i     (wfi_i),
        .cfg_lvl   (cfg_lvl),
        .wake_idle (wake_idle),
        .wake_stby (wake_stby),
        .state     (state)
    );

    sleep_out_dec #(.NGCLK(NGCLK), .NOSC(NOSC), .VREG_W(VREG_W)) u_dec (
        .state         (state),
        .sw_any        (sw_any),
        .gclk_req      (gclk_req),
        .osc_req       (osc_req),
        .osc_ondemand  (osc_ondemand),
        .osc_runstdby  (osc_runstdby),
        .stby_vreg_cfg (stby_vreg_cfg),
        .stby_ram_lp   (stby_ram_lp),
        .cpu_clk_en    (cpu_clk_en),
        .ahb_clk_en    (ahb_clk_en),
        .apb_clk_en    (apb_clk_en),
        .main_clk_en   (main_clk_en),
        .gclk_en       (gclk_en),
        .osc_run       (osc_run),
        .vreg_lowpwr   (vreg_lowpwr),
        .vreg_sel      (vreg_sel),
        .ram_lowpwr    (ram_lowpwr),
        .mode_o        (mode_o)
    );

    assign cfg_rd_lvl = cfg_lvl;

endmodule

// File: rtl/sleep_ctrl_chk.sv
module sleep_ctrl_chk #(
    parameter int NPERIPH = 4,
    parameter int NOSC    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wfi_i,
    input logic [NPERIPH-1:0] irq_req,
    input logic [NPERIPH-1:0] irq_async,
    input logic [NPERIPH-1:0] per_runstdby,
    input logic [NOSC-1:0]    osc_req,
    input logic [NOSC-1:0]    osc_ondemand,
    input logic               cpu_clk_en,
    input logic               ahb_clk_en,
    input logic               apb_clk_en,
    input logic               main_clk_en,
    input logic [NOSC-1:0]    osc_run,
    input logic               vreg_lowpwr,
    input logic               ram_lowpwr,
    input logic [1:0]         mode_o
);
    logic stby_wake;
    assign stby_wake = |(irq_req & (irq_async | per_runstdby));

    p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd0) |-> !cpu_clk_en);

    p_stby_main_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> (!main_clk_en && !cpu_clk_en));

    p_stby_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && !stby_wake) |=> (mode_o == 2'd2));

    p_no_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && wfi_i && stby_wake) |=> cpu_clk_en);

    p_cpu_needs_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (main_clk_en && ahb_clk_en && apb_clk_en));

    p_wake_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> ($past(ahb_clk_en) && $past(apb_clk_en) && $past(main_clk_en, 2)));

    p_lp_only_stby_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd2) |-> (!vreg_lowpwr && !ram_lowpwr));

    for (genvar o = 0; o < NOSC; o++) begin : g_osc_chk
        p_ondemand_r10: assert property (@(posedge clk) disable iff (!rst_n)
            osc_ondemand[o] |-> (osc_run[o] == osc_req[o]));
    end

endmodule

bind sleep_ctrl sleep_ctrl_chk #(.NPERIPH(NPERIPH), .NOSC(NOSC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wfi_i        (wfi_i),
    .irq_req      (irq_req),
    .irq_async    (irq_async),
    .per_runstdby (per_runstdby),
    .osc_req      (osc_req),
    .osc_ondemand (osc_ondemand),
    .cpu_clk_en   (cpu_clk_en),
    .ahb_clk_en   (ahb_clk_en),
    .apb_clk_en   (apb_clk_en),
    .main_clk_en  (main_clk_en),
    .osc_run      (osc_run),
    .vreg_lowpwr  (vreg_lowpwr),
    .ram_lowpwr   (ram_lowpwr),
    .mode_o       (mode_o)
);

// File: tb/sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_ctrl_tb_top;
    localparam int NP = 4;
    localparam int NG = 3;
    localparam int NO = 2;
    localparam int VW = 2;
    localparam int BD = 2;

    // vector fields: [13] level, [12:9] irq, [8:5] async, [4:1] runstdby, [0] expect wake
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 4'b0001, 4'b0000, 4'b0000, 1'b1},
        {1'b0, 4'b0100, 4'b0100, 4'b0000, 1'b1},
        {1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
        {1'b1, 4'b0010, 4'b0010, 4'b0000, 1'b1},
        {1'b1, 4'b0010, 4'b0000, 4'b0000, 1'b0},
        {1'b1, 4'b1000, 4'b0000, 4'b1000, 1'b1},
        {1'b1, 4'b1000, 4'b0000, 4'b0100, 1'b0},
        {1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 0, cfg_wr_lvl = 0, cfg_rd_lvl;
    logic wfi_i = 0;
    logic [NP-1:0] irq_req = '0, irq_async = '0, per_runstdby = '0, sw_active = '0;
    logic [NG-1:0] gclk_req = '0, gclk_en;
    logic [NO-1:0] osc_req = '0, osc_ondemand = '0, osc_runstdby = '0, osc_run;
    logic [VW-1:0] stby_vreg_cfg = '0, vreg_sel;
    logic stby_ram_lp = 0;
    logic cpu_clk_en, ahb_clk_en, apb_clk_en, main_clk_en, vreg_lowpwr, ram_lowpwr;
    logic [1:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sleep_ctrl #(.NPERIPH(NP), .NGCLK(NG), .NOSC(NO), .VREG_W(VW), .BRIDGE_DLY(BD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_lvl(cfg_wr_lvl),
        .cfg_rd_lvl(cfg_rd_lvl), .wfi_i(wfi_i), .irq_req(irq_req), .irq_async(irq_async),
        .per_runstdby(per_runstdby), .sw_active(sw_active), .gclk_req(gclk_req),
        .osc_req(osc_req), .osc_ondemand(osc_ondemand), .osc_runstdby(osc_runstdby),
        .stby_vreg_cfg(stby_vreg_cfg), .stby_ram_lp(stby_ram_lp), .cpu_clk_en(cpu_clk_en),
        .ahb_clk_en(ahb_clk_en), .apb_clk_en(apb_clk_en), .main_clk_en(main_clk_en),
        .gclk_en(gclk_en), .osc_run(osc_run), .vreg_lowpwr(vreg_lowpwr), .vreg_sel(vreg_sel),
        .ram_lowpwr(ram_lowpwr), .mode_o(mode_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_lvl(input logic lvl);
        cfg_wr_en = 1; cfg_wr_lvl = lvl;
        tick();
        cfg_wr_en = 0;
        repeat (3) tick();
    endtask

    task automatic enter_sleep();
        wfi_i = 1;
        tick();
        wfi_i = 0;
    endtask

    task automatic force_wake();
        irq_req = 4'b0001; irq_async = 4'b0001;
        tick();
        irq_req = '0; irq_async = '0; per_runstdby = '0;
        repeat (2) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R13 reset state
        check("R13 mode", mode_o, 0);
        check("R13 clocks", {cpu_clk_en, ahb_clk_en, apb_clk_en, main_clk_en}, 4'hF);
        check("R1 reset level", cfg_rd_lvl, 0);
        rst_n = 1;
        tick();
        check("R13 after release", {cpu_clk_en, main_clk_en, mode_o}, 4'b1100);

        // R1 bridge delay
        cfg_wr_en = 1; cfg_wr_lvl = 1;
        tick();
        cfg_wr_en = 0;
        check("R1 not after one edge", cfg_rd_lvl, 0);
        tick();
        check("R1 not after two edges", cfg_rd_lvl, 0);
        tick();
        check("R1 visible after three edges", cfg_rd_lvl, 1);

        // R2 R6 R7 table walk
        for (int k = 0; k < 8; k++) begin
            logic [13:0] v;
            v = VEC[k];
            write_lvl(v[13]);
            enter_sleep();
            check("R2 entered level", mode_o, v[13] ? 2 : 1);
            irq_req = v[12:9]; irq_async = v[8:5]; per_runstdby = v[4:1];
            tick();
            if (v[0]) begin
                check("R6/R7 woke", {mode_o, cpu_clk_en, main_clk_en}, 4'b0001);
                irq_req = '0; irq_async = '0; per_runstdby = '0;
                repeat (2) tick();
            end else begin
                check("R7 stays asleep", {mode_o, cpu_clk_en}, {v[13] ? 2'd2 : 2'd1, 1'b0});
                force_wake();
            end
            check("R9 running again", cpu_clk_en, 1);
        end

        // R8 pending qualifying request blocks entry
        write_lvl(1);
        irq_req = 4'b0100; irq_async = 4'b0100;
        enter_sleep();
        check("R8 no entry", {mode_o, cpu_clk_en}, 3'b001);
        // R8 sync request without run-in-standby does not block STANDBY
        irq_req = 4'b0010; irq_async = '0;
        enter_sleep();
        check("R8 entered despite sync request", mode_o, 2);
        irq_req = '0;
        force_wake();

        // R9 staged restore from IDLE
        write_lvl(0);
        enter_sleep();
        irq_req = 4'b1000;
        tick();
        irq_req = '0;
        check("R9 stage main", {mode_o, main_clk_en, ahb_clk_en, apb_clk_en, cpu_clk_en}, 6'b001000);
        tick();
        check("R9 stage bus", {main_clk_en, ahb_clk_en, apb_clk_en, cpu_clk_en}, 4'b1110);
        tick();
        check("R9 stage cpu", cpu_clk_en, 1);

        // R3 IDLE outputs, R10 oscillators in IDLE
        gclk_req = 3'b101; osc_ondemand = 2'b01; osc_req = 2'b00; osc_runstdby = 2'b00;
        enter_sleep();
        check("R3 idle enables", {cpu_clk_en, ahb_clk_en, apb_clk_en, main_clk_en}, 4'b0001);
        check("R3 idle gclk", gclk_en, 3'b101);
        check("R10 idle osc", osc_run, 2'b10);
        osc_req = 2'b01;
        tick();
        check("R10 idle on demand", osc_run, 2'b11);
        check("R11 idle regulator", {vreg_lowpwr, vreg_sel, ram_lowpwr}, 4'b0000);
        sw_active = 4'b0100;
        tick();
        check("R5 idle sleepwalk", {ahb_clk_en, apb_clk_en, cpu_clk_en, mode_o}, 5'b11001);
        sw_active = '0; osc_req = '0;
        force_wake();

        // R4 R5 R10 R11 R12 STANDBY
        write_lvl(1);
        stby_vreg_cfg = 2'b10; stby_ram_lp = 1; osc_runstdby = 2'b10;
        enter_sleep();
        check("R4 stby enables", {cpu_clk_en, ahb_clk_en, apb_clk_en, main_clk_en}, 4'b0000);
        check("R4 stby gclk", gclk_en, 3'b000);
        check("R10 stby osc", osc_run, 2'b10);
        check("R11 stby regulator", {vreg_lowpwr, vreg_sel}, 3'b110);
        check("R12 stby ram", ram_lowpwr, 1);
        osc_runstdby = 2'b00;
        tick();
        check("R10 stby osc off", osc_run, 2'b00);
        sw_active = 4'b0001;
        tick();
        check("R5 stby sleepwalk", {ahb_clk_en, apb_clk_en, cpu_clk_en, main_clk_en, mode_o}, 6'b110010);
        check("R5 stby gclk", gclk_en, 3'b101);
        sw_active = '0;
        tick();
        check("R5 sleepwalk ends", {ahb_clk_en, gclk_en}, 4'b0000);
        stby_ram_lp = 0;
        tick();
        check("R12 ram select off", ram_lowpwr, 0);
        force_wake();
        check("R11 after wake", {vreg_lowpwr, vreg_sel, ram_lowpwr}, 4'b0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule